// File: doc/BRIEF.md
# Interleaved Block-Fill Memory Sequencer

This block answers a cache-line fill from main memory and reproduces the fill latency of three memory organisations. A requester presents a block index. The sequencer then returns the words of that block in ascending address order, each word with a valid strobe. It pulses a done flag together with the final word. The word storage is a register array. Its contents are seeded at reset, so every word carries a value that can be predicted from its address.

A build-time parameter chooses the organisation:
- **Narrow:** one bank, one word per access.
- **Wide:** one bank row of two words per access, delivered together on a two-lane output.
- **Interleaved:** M banks. Word A sits in bank A mod M at row A div M. All banks are accessed together after one shared address cycle, and the words are then streamed out one per cycle.

Each access is costed as an address phase, an array phase and a transfer phase, with default lengths of 1, 6 and 1 cycles.

Top module: `blockFillSeq`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` is 2'b00 and `fillDone` is 0.
- R2: In narrow mode a 4-word fill takes 32 cycles. The count runs from the accepting edge to the cycle that shows `fillDone`, inclusive. Every word appears on lane 0 with `rspValid` = 2'b01.
- R3: In wide mode a 4-word fill takes 16 cycles. Each transfer shows `rspValid` = 2'b11, with the lower-address word in `rspData[31:0]` and the next word in `rspData[63:32]`.
- R4: In interleaved mode with 4 banks, a 4-word fill takes 11 cycles (1 + 6 + 4). The words appear on lane 0 in the last 4 cycles, one per cycle.
- R5: The word at address A (8-bit word address) reads as the 32-bit value {16'h0000, ~A, A}. In interleaved mode it is held in bank A mod M at row A div M.
- R6: A fill of block index B returns word addresses 4B, 4B+1, 4B+2 and 4B+3 in that order.
- R7: `fillDone` is high for one cycle, the same cycle as the last word of the block.
- R8: While a fill is in progress, `reqReady` is 0. `reqValid` and `reqBlock` have no effect on the words returned.
- R9: `reqReady` rises in the cycle after `fillDone`. A request held pending is accepted at the next edge, so a back-to-back fill ends 12 cycles after the previous done in interleaved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Fill request present |
| reqBlock | input | 6 | Block index; the first word address is 4 × index |
| reqReady | output | 1 | Sequencer idle; a request is taken on this edge |
| rspValid | output | 2 | Per-lane word strobe (bit 1 used in wide mode only) |
| rspData | output | 64 | Lane 0 in bits 31:0, lane 1 in bits 63:32 |
| fillDone | output | 1 | Pulses with the final word of the block |

## Verification
The completion of one fill and the taking of the next request can meet at the boundary around `fillDone`. The bench provokes this by keeping `reqValid` high for the whole fill and changing `reqBlock` partway through. The first fill must still return its original block at the unchanged latency. The pending request must be taken only on the edge after done, which is judged by the exact cycle count of the second fill and by its data.

// File: rtl/fillSeqPkg.sv
package fillSeqPkg;

  typedef enum logic [1:0] {
    MODE_NARROW      = 2'd0,
    MODE_WIDE        = 2'd1,
    MODE_INTERLEAVED = 2'd2
  } fillMode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACC  = 2'd2,
    PH_XFER = 2'd3
  } fillPhase_e;

  // Strobes from control to datapath; index fields sized for up to 256 rounds/lanes.
  typedef struct packed {
    logic       start;
    logic       capture;
    logic       emit;
    logic       last;
    logic [7:0] round;
    logic [7:0] lane;
  } seqStrobe_t;

endpackage

// File: rtl/fillSeqCtrl.sv
module fillSeqCtrl
  import fillSeqPkg::*;
#(
  parameter int ROUNDS     = 1,
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_CYC = 6,
  parameter int XFER_PHASE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strb,
  output logic       fillDone
);

  localparam int MAXC01 = (ADDR_CYC > ACCESS_CYC) ? ADDR_CYC : ACCESS_CYC;
  localparam int MAXC   = (MAXC01 > XFER_PHASE) ? MAXC01 : XFER_PHASE;
  localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int TOTAL  = ROUNDS * (ADDR_CYC + ACCESS_CYC + XFER_PHASE);

  fillPhase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [RND_W-1:0] round;
  logic             cntEnd;

  always_comb begin
    unique case (phase)
      PH_ADDR: cntEnd = (cnt == CNT_W'(ADDR_CYC - 1));
      PH_ACC:  cntEnd = (cnt == CNT_W'(ACCESS_CYC - 1));
      PH_XFER: cntEnd = (cnt == CNT_W'(XFER_PHASE - 1));
      default: cntEnd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      round <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (reqValid) begin
          phase <= PH_ADDR;
          cnt   <= '0;
          round <= '0;
        end
        PH_ADDR: if (cntEnd) begin
          phase <= PH_ACC;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_ACC: if (cntEnd) begin
          phase <= PH_XFER;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_XFER: if (cntEnd) begin
          cnt <= '0;
          if (round == RND_W'(ROUNDS - 1)) phase <= PH_IDLE;
          else begin
            round <= round + 1'b1;
            phase <= PH_ADDR;
          end
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign reqReady     = (phase == PH_IDLE);
  assign strb.start   = reqReady && reqValid;
  assign strb.capture = (phase == PH_ACC) && cntEnd;
  assign strb.emit    = (phase == PH_XFER);
  assign strb.last    = strb.emit && cntEnd && (round == RND_W'(ROUNDS - 1));
  assign strb.round   = 8'(round);
  assign strb.lane    = 8'(cnt);
  assign fillDone     = strb.last;

  // Independent age counter for the latency check.
  logic [15:0] fillAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               fillAge <= '0;
    else if (strb.start)     fillAge <= 16'd1;
    else if (!reqReady)      fillAge <= fillAge + 16'd1;
  end

  // R2 R3 R4: done arrives exactly TOTAL cycles after acceptance
  a_r4_fill_latency: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> fillAge == 16'(TOTAL));
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> reqReady);
  a_r8_leave_idle_on_req: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> !fillDone);

endmodule

// File: rtl/fillSeqData.sv
module fillSeqData
  import fillSeqPkg::*;
#(
  parameter fillMode_e MODE        = MODE_INTERLEAVED,
  parameter int        DATA_W      = 32,
  parameter int        ADDR_W      = 8,
  parameter int        BLOCK_WORDS = 4,
  parameter int        LANES       = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0]  reqBlock,
  input  seqStrobe_t                             strb,
  output logic [1:0]                             rspValid,
  output logic [2*DATA_W-1:0]                    rspData
);

  localparam int BLK_SH  = $clog2(BLOCK_WORDS);
  localparam int BLK_W   = ADDR_W - BLK_SH;
  localparam int LANE_SH = $clog2(LANES);
  localparam int ROW_W   = ADDR_W - LANE_SH;
  localparam int DEPTH   = (1 << ADDR_W) / LANES;
  localparam int STEP    = (MODE == MODE_WIDE) ? 2 : 1;

  function automatic logic [DATA_W-1:0] seedWord(int wa);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(wa);
    return DATA_W'({~a, a});
  endfunction

  logic [BLK_W-1:0]  blkReg;
  logic [ADDR_W-1:0] blockBase;
  logic [ROW_W-1:0]  rowIdx;
  logic [DATA_W-1:0] rowBuf [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           blkReg <= '0;
    else if (strb.start) blkReg <= reqBlock;
  end

  assign blockBase = ADDR_W'(blkReg) << BLK_SH;
  // Modulo/divide by a power-of-two bank count is a shift.
  assign rowIdx    = ROW_W'(blockBase >> LANE_SH) + ROW_W'(strb.round);

  for (genvar b = 0; b < LANES; b++) begin : gBank
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] bufQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < DEPTH; r++) cells[r] <= seedWord(r * LANES + b);
        bufQ <= '0;
      end else if (strb.capture) begin
        bufQ <= cells[rowIdx];
      end
    end
    assign rowBuf[b] = bufQ;
  end

  if (MODE == MODE_WIDE) begin : gOutWide
    assign rspData  = {rowBuf[1], rowBuf[0]};
    assign rspValid = {strb.emit, strb.emit};
  end else if (LANES == 1) begin : gOutNarrow
    assign rspData  = {{DATA_W{1'b0}}, rowBuf[0]};
    assign rspValid = {1'b0, strb.emit};
  end else begin : gOutInter
    logic [LANE_SH-1:0] sel;
    assign sel      = strb.lane[LANE_SH-1:0];
    assign rspData  = {{DATA_W{1'b0}}, rowBuf[sel]};
    assign rspValid = {1'b0, strb.emit};
  end

  // Ordering checker state
  logic [ADDR_W-1:0] emitAddr, prevAddr;
  logic              seen;
  assign emitAddr = (ADDR_W'(rowIdx) << LANE_SH) + ADDR_W'(strb.lane);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen     <= 1'b0;
      prevAddr <= '0;
    end else if (strb.start) begin
      seen <= 1'b0;
    end else if (strb.emit) begin
      seen     <= 1'b1;
      prevAddr <= emitAddr;
    end
  end

  a_r6_first_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit && !seen |-> emitAddr == blockBase);
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit && seen |-> emitAddr == prevAddr + ADDR_W'(STEP));

endmodule

// File: rtl/blockFillSeq.sv
module blockFillSeq
  import fillSeqPkg::*;
#(
  parameter fillMode_e MODE        = MODE_INTERLEAVED,
  parameter int        DATA_W      = 32,
  parameter int        ADDR_W      = 8,
  parameter int        BLOCK_WORDS = 4,
  parameter int        BANKS       = 4,
  parameter int        ADDR_CYC    = 1,
  parameter int        ACCESS_CYC  = 6,
  parameter int        XFER_CYC    = 1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0] reqBlock,
  output logic                                  reqReady,
  output logic [1:0]                            rspValid,
  output logic [2*DATA_W-1:0]                   rspData,
  output logic                                  fillDone
);

  localparam int LANES      = (MODE == MODE_NARROW) ? 1 : (MODE == MODE_WIDE) ? 2 : BANKS;
  localparam int ROUNDS     = BLOCK_WORDS / LANES;
  localparam int XFER_PHASE = (MODE == MODE_INTERLEAVED) ? LANES * XFER_CYC : XFER_CYC;

  seqStrobe_t strb;

  fillSeqCtrl #(
    .ROUNDS(ROUNDS), .ADDR_CYC(ADDR_CYC),
    .ACCESS_CYC(ACCESS_CYC), .XFER_PHASE(XFER_PHASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strb(strb), .fillDone(fillDone)
  );

  fillSeqData #(
    .MODE(MODE), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .BLOCK_WORDS(BLOCK_WORDS), .LANES(LANES)
  ) i_data (
    .clk(clk), .rstN(rstN), .reqBlock(reqBlock), .strb(strb),
    .rspValid(rspValid), .rspData(rspData)
  );

  a_r7_done_with_word: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> rspValid[0]);
  a_r8_busy_while_emit: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != 2'b00) |-> !reqReady);

endmodule

// File: tb/test_blockFillSeq.sv
`timescale 1ns/1ps
module test_blockFillSeq;
  import fillSeqPkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid [3];
  logic [5:0]  reqBlock [3];
  logic        reqReady [3];
  logic [1:0]  rspValid [3];
  logic [63:0] rspData  [3];
  logic        fillDone [3];

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // index 0: narrow, 1: wide, 2: interleaved
  blockFillSeq #(.MODE(MODE_NARROW)) i_blockFillSeqNarrow (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqBlock(reqBlock[0]),
    .reqReady(reqReady[0]), .rspValid(rspValid[0]), .rspData(rspData[0]), .fillDone(fillDone[0]));
  blockFillSeq #(.MODE(MODE_WIDE)) i_blockFillSeqWide (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqBlock(reqBlock[1]),
    .reqReady(reqReady[1]), .rspValid(rspValid[1]), .rspData(rspData[1]), .fillDone(fillDone[1]));
  blockFillSeq #(.MODE(MODE_INTERLEAVED)) i_blockFillSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[2]), .reqBlock(reqBlock[2]),
    .reqReady(reqReady[2]), .rspValid(rspValid[2]), .rspData(rspData[2]), .fillDone(fillDone[2]));

  function automatic logic [31:0] expWord(int a);
    logic [7:0] w;
    w = 8'(a);
    return {16'h0000, ~w, w};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startReq(int m, int blk);
    @(negedge clk);
    reqValid[m] = 1'b1;
    reqBlock[m] = 6'(blk);
  endtask

  // Samples each cycle after the accepting edge; holdBlk >= 0 keeps the request pending.
  task automatic collectFill(int m, int blk, int expCyc, int holdBlk, string req);
    int  c = 0;
    int  idx = 0;
    bit  fin = 0;
    while (!fin && c < 200) begin
      @(negedge clk);
      c++;
      if (c == 2) begin
        check(reqReady[m] == 1'b0, "R8", "ready while busy", reqReady[m], 0);
        if (holdBlk >= 0) reqBlock[m] = 6'(holdBlk);
        else reqValid[m] = 1'b0;
      end
      if (rspValid[m] != 2'b00) begin
        check(rspValid[m] == ((m == 1) ? 2'b11 : 2'b01), req, "lane strobes",
              rspValid[m], (m == 1) ? 2 : 1);
        for (int l = 0; l < 2; l++) begin
          if (rspValid[m][l]) begin
            check(rspData[m][32*l +: 32] == expWord(blk * 4 + idx), "R5 R6", "word data",
                  rspData[m][32*l +: 32], expWord(blk * 4 + idx));
            idx++;
          end
        end
      end
      if (fillDone[m]) fin = 1;
    end
    check(fin && c == expCyc, req, "fill cycles", c, expCyc);
    check(idx == 4, "R7", "words before done", idx, 4);
  endtask

  task automatic testReset();
    for (int m = 0; m < 3; m++) begin
      check(reqReady[m] == 1'b1, "R1", "ready after reset", reqReady[m], 1);
      check(rspValid[m] == 2'b00, "R1", "valid after reset", rspValid[m], 0);
      check(fillDone[m] == 1'b0, "R1", "done after reset", fillDone[m], 0);
    end
  endtask

  task automatic testNarrow();
    int blks[3] = '{0, 37, 63};
    foreach (blks[i]) begin
      startReq(0, blks[i]);
      collectFill(0, blks[i], 32, -1, "R2");
    end
  endtask

  task automatic testWide();
    int blks[3] = '{0, 21, 63};
    foreach (blks[i]) begin
      startReq(1, blks[i]);
      collectFill(1, blks[i], 16, -1, "R3");
    end
  endtask

  task automatic testInterleaved();
    int blks[3] = '{0, 5, 63};
    foreach (blks[i]) begin
      startReq(2, blks[i]);
      collectFill(2, blks[i], 11, -1, "R4");
    end
  endtask

  // R8 R9: request held through the fill with a changed block, then taken after done
  task automatic testBusyOverlap();
    startReq(2, 9);
    collectFill(2, 9, 11, 50, "R8");
    @(negedge clk);
    check(reqReady[2] == 1'b1, "R9", "ready after done", reqReady[2], 1);
    collectFill(2, 50, 11, -1, "R9");
    startReq(0, 12);
    collectFill(0, 12, 32, 40, "R8");
    @(negedge clk);
    collectFill(0, 40, 32, -1, "R9");
  endtask

  initial begin
    #750000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    for (int m = 0; m < 3; m++) begin
      reqValid[m] = 1'b0;
      reqBlock[m] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNarrow();
    testWide();
    testInterleaved();
    testBusyOverlap();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule